// File: doc/BRIEF.md
# Display Raster Timing with Global Sync and Double-Buffered Surface Registers

The block counts pixel and line positions on a pixel clock and derives active video, vertical blanking and a vertical sync pulse from programmed line numbers. Inside vertical blanking it emits three global sync pulses, each one line long: a fetch start pulse (`vstartup`), a commit pulse (`vupdate`) and a ready pulse (`vready`). Their line positions are set on their own inputs and have no tie to the vertical sync position.

Two configuration words, a surface base address and a scan configuration word, are held as pending/active pairs. A host may write the pending copies at any time in the frame. Both active copies load together at the first pixel of the commit line. Writes therefore act as a mailbox: only the last value written before that point takes effect. A sticky flag shows that an update is waiting. A one-cycle flip-done event reports each commit that carried new data. A line check stops all three pulses, and with them any commit, while the programmed sync lines are out of range or coincide.

Top module: `gsync_timing`

## Requirements
- R1: While `rst_n` is low, `surf_addr`, `scan_cfg`, `upd_pending` and `flip_done` are all 0, and the raster position is pixel 0 of line 0.
- R2: The pixel counter runs from 0 to `h_total-1`. The line counter steps when the pixel counter wraps and runs from 0 to `v_total-1`. `de` is high when the pixel is below `h_active` and the line is below `v_active`. `vblank` is high when the line is `v_active` or greater.
- R3: `vsync` is high on lines L with `vs_start <= L < vs_end`, whatever the sync pulse lines are.
- R4: With a valid line setup, `vstartup`, `vupdate` and `vready` are each high for the whole of the line equal to `ln_startup`, `ln_update` and `ln_ready` respectively. They fall only in blanking and never overlap.
- R5: `cfg_err` is high when any of the three sync lines is below `v_active` or at or above `v_total`, or when two of them are equal. While it is high, all three pulses stay low and no commit happens.
- R6: A host write (`wr_en` high) with `wr_sel`=0 loads `wr_data` into the pending surface address, and one with `wr_sel`=1 loads `wr_data[XW-1:0]` into the pending scan word. Neither active output changes until the commit edge, which is the clock edge at which the line equals `ln_update` and the pixel is 0. After that edge both outputs equal the last value written before it.
- R7: A write made on the commit edge itself stays pending and is committed at the next commit edge.
- R8: `upd_pending` is set by any write and cleared by a commit edge that has no write in the same cycle.
- R9: `flip_done` is high for exactly the one cycle after a commit edge at which `upd_pending` was set. A commit edge with nothing pending raises no event and leaves the active values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_total | input | HW | Pixels per line |
| h_active | input | HW | Visible pixels per line |
| v_total | input | VW | Lines per frame |
| v_active | input | VW | Visible lines per frame |
| vs_start | input | VW | First vertical sync line |
| vs_end | input | VW | Line after the last vertical sync line |
| ln_startup | input | VW | Line of the fetch start pulse |
| ln_update | input | VW | Line of the commit pulse |
| ln_ready | input | VW | Line of the ready pulse |
| wr_en | input | 1 | Host write strobe for a pending register |
| wr_sel | input | 1 | 0 selects surface address, 1 selects scan word |
| wr_data | input | AW | Host write data |
| surf_addr | output | AW | Active surface base address |
| scan_cfg | output | XW | Active scan configuration word |
| upd_pending | output | 1 | A written value is waiting for commit |
| flip_done | output | 1 | One-cycle event after a commit of new data |
| cfg_err | output | 1 | Sync line setup is invalid |
| de | output | 1 | Active video |
| vblank | output | 1 | Vertical blanking |
| vsync | output | 1 | Vertical sync |
| vstartup | output | 1 | Fetch start pulse |
| vupdate | output | 1 | Commit pulse |
| vready | output | 1 | Ready pulse |

## Verification
`de`, `vblank`, `vsync`, the three pulses and `cfg_err` decode the current raster position with no added delay. The bench samples them at the falling edge and compares them with values it computes from the number of rising edges since reset. Register effects appear one edge late: active values and the cleared pending flag show up in the cycle after the commit edge, and `flip_done` is high in that same cycle. The bench's model updates on the same rising edge, so both are compared at the following falling edge. Directed checks sit on the sample just before the commit edge and the one just after it.

// File: rtl/gsync_timing.sv
module gsync_timing #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int AW = 32,
  parameter int XW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_total,
  input  logic [HW-1:0] h_active,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_active,
  input  logic [VW-1:0] vs_start,
  input  logic [VW-1:0] vs_end,
  input  logic [VW-1:0] ln_startup,
  input  logic [VW-1:0] ln_update,
  input  logic [VW-1:0] ln_ready,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] surf_addr,
  output logic [XW-1:0] scan_cfg,
  output logic          upd_pending,
  output logic          flip_done,
  output logic          cfg_err,
  output logic          de,
  output logic          vblank,
  output logic          vsync,
  output logic          vstartup,
  output logic          vupdate,
  output logic          vready
);

  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  logic [AW-1:0] nxt_addr;
  logic [XW-1:0] nxt_scan;
  logic          commit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hpos <= '0;
      vpos <= '0;
    end else if (hpos == h_total - 1'b1) begin
      hpos <= '0;
      vpos <= (vpos == v_total - 1'b1) ? '0 : vpos + 1'b1;
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  function automatic logic in_blank(input logic [VW-1:0] ln);
    return (ln >= v_active) && (ln < v_total);
  endfunction

  assign cfg_err  = !in_blank(ln_startup) || !in_blank(ln_update) || !in_blank(ln_ready)
                 || (ln_startup == ln_update) || (ln_update == ln_ready)
                 || (ln_startup == ln_ready);
  assign de       = (hpos < h_active) && (vpos < v_active);
  assign vblank   = (vpos >= v_active);
  assign vsync    = (vpos >= vs_start) && (vpos < vs_end);
  assign vstartup = !cfg_err && (vpos == ln_startup);
  assign vupdate  = !cfg_err && (vpos == ln_update);
  assign vready   = !cfg_err && (vpos == ln_ready);
  assign commit   = vupdate && (hpos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_addr    <= '0;
      nxt_scan    <= '0;
      surf_addr   <= '0;
      scan_cfg    <= '0;
      upd_pending <= 1'b0;
      flip_done   <= 1'b0;
    end else begin
      if (wr_en && !wr_sel) nxt_addr <= wr_data;
      if (wr_en &&  wr_sel) nxt_scan <= wr_data[XW-1:0];
      if (commit) begin
        surf_addr <= nxt_addr;
        scan_cfg  <= nxt_scan;
      end
      flip_done   <= commit && upd_pending;
      upd_pending <= wr_en || (upd_pending && !commit);
    end
  end

  p_pulse_in_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vstartup || vupdate || vready) |-> vblank);
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vstartup, vupdate, vready}));
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> $stable(surf_addr) && $stable(scan_cfg));
  p_hold_until_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(surf_addr) && $stable(scan_cfg));
  p_pending_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_en) |=> !upd_pending);
  p_flip_after_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flip_done |-> $past(commit) && $past(upd_pending));

endmodule

// File: tb/tb_gsync_timing.sv
module tb_gsync_timing;
  localparam int HW = 12, VW = 12, AW = 32, XW = 16;
  localparam int HT = 8, VT = 12, FR = HT * VT;

  logic clk = 0, rst_n = 0;
  logic [HW-1:0] h_total = HT, h_active = 6;
  logic [VW-1:0] v_total = VT, v_active = 8, vs_start = 9, vs_end = 11;
  logic [VW-1:0] ln_startup = 8, ln_update = 9, ln_ready = 10;
  logic wr_en = 0, wr_sel = 0;
  logic [AW-1:0] wr_data = 0;
  logic [AW-1:0] surf_addr;
  logic [XW-1:0] scan_cfg;
  logic upd_pending, flip_done, cfg_err, de, vblank, vsync, vstartup, vupdate, vready;

  gsync_timing #(.HW(HW), .VW(VW), .AW(AW), .XW(XW)) dut (
    .clk(clk), .rst_n(rst_n), .h_total(h_total), .h_active(h_active),
    .v_total(v_total), .v_active(v_active), .vs_start(vs_start), .vs_end(vs_end),
    .ln_startup(ln_startup), .ln_update(ln_update), .ln_ready(ln_ready),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .surf_addr(surf_addr), .scan_cfg(scan_cfg), .upd_pending(upd_pending),
    .flip_done(flip_done), .cfg_err(cfg_err), .de(de), .vblank(vblank),
    .vsync(vsync), .vstartup(vstartup), .vupdate(vupdate), .vready(vready));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  logic [AW-1:0] m_paddr = 0, m_addr = 0;
  logic [XW-1:0] m_pscan = 0, m_scan = 0;
  logic m_pend = 0, m_flip = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_err();
    logic bad = 0;
    int l[3] = '{int'(ln_startup), int'(ln_update), int'(ln_ready)};
    foreach (l[i]) if (l[i] < 8 || l[i] >= VT) bad = 1;
    return bad || l[0] == l[1] || l[1] == l[2] || l[0] == l[2];
  endfunction

  function automatic int pos(); return cyc % FR; endfunction

  always @(posedge clk) if (rst_n) begin
    logic cm;
    cm = !m_err() && (pos() == int'(ln_update) * HT);
    cyc <= cyc + 1;
    if (wr_en && !wr_sel) m_paddr <= wr_data;
    if (wr_en && wr_sel) m_pscan <= wr_data[XW-1:0];
    if (cm) begin m_addr <= m_paddr; m_scan <= m_pscan; end
    m_flip <= cm && m_pend;
    m_pend <= wr_en || (m_pend && !cm);
  end

  always @(negedge clk) if (rst_n && !done) begin
    int hh, vv;
    logic e;
    hh = pos() % HT; vv = pos() / HT; e = m_err();
    chk("R2 de", de, hh < 6 && vv < 8);
    chk("R2 vblank", vblank, vv >= 8);
    chk("R3 vsync", vsync, vv >= int'(vs_start) && vv < int'(vs_end));
    chk("R5 cfg_err", cfg_err, e);
    chk("R4 vstartup", vstartup, !e && vv == int'(ln_startup));
    chk("R4 vupdate", vupdate, !e && vv == int'(ln_update));
    chk("R4 vready", vready, !e && vv == int'(ln_ready));
    chk("R6 surf_addr", surf_addr, m_addr);
    chk("R6 scan_cfg", scan_cfg, m_scan);
    chk("R8 upd_pending", upd_pending, m_pend);
    chk("R9 flip_done", flip_done, m_flip);
  end

  task automatic wait_pos(input int p);
    do @(negedge clk); while (pos() != p);
  endtask

  task automatic host_wr(input logic sel, input logic [AW-1:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 surf_addr", surf_addr, 0);
    chk("R1 scan_cfg", scan_cfg, 0);
    chk("R1 upd_pending", upd_pending, 0);
    chk("R1 flip_done", flip_done, 0);
    chk("R1 de at origin", de, 1);
    rst_n = 1;
    // frame 0: mailbox writes, only the last address survives
    wait_pos(5);  host_wr(0, 32'hA000_0001);
    wait_pos(30); host_wr(0, 32'hA000_0002);
    wait_pos(50); host_wr(1, 32'h0000_5A5A);
    wait_pos(66); host_wr(0, 32'hA000_0003);
    wait_pos(72);
    chk("R6 held before commit", surf_addr, 0);
    chk("R8 pending set", upd_pending, 1);
    @(negedge clk);
    chk("R6 last write wins", surf_addr, 32'hA000_0003);
    chk("R6 scan word together", scan_cfg, 16'h5A5A);
    chk("R9 flip event", flip_done, 1);
    @(negedge clk);
    chk("R9 flip one cycle", flip_done, 0);
    // frame 1: write on the commit edge itself
    wait_pos(72); host_wr(0, 32'hB000_0001);
    chk("R7 not taken on own edge", surf_addr, 32'hA000_0003);
    chk("R7 still pending", upd_pending, 1);
    wait_pos(73);
    chk("R7 taken next frame", surf_addr, 32'hB000_0001);
    // frame 3: nothing pending
    wait_pos(73);
    chk("R9 no flip when idle", flip_done, 0);
    chk("R9 active unchanged", surf_addr, 32'hB000_0001);
    // invalid setups
    wait_pos(0); ln_ready = 9;
    wait_pos(20); host_wr(0, 32'hC000_0001);
    wait_pos(73);
    chk("R5 no commit in error", surf_addr, 32'hB000_0001);
    wait_pos(0); ln_ready = 3;
    wait_pos(0); ln_ready = 12;
    wait_pos(0); ln_startup = 11; ln_ready = 10; vs_start = 2; vs_end = 5;
    wait_pos(73);
    chk("R5 commit after repair", surf_addr, 32'hC000_0001);
    wait_pos(0); ln_startup = 8; ln_update = 11; ln_ready = 10;
    wait_pos(40); host_wr(1, 32'h0000_0077);
    wait_pos(89);
    chk("R6 moved commit line", scan_cfg, 16'h0077);
    wait_pos(0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule